// File: doc/BRIEF.md
# Flash Write-Buffer Burst Programmer

This block drives one buffered program operation on a parallel NOR flash that uses a status-register command set. A caller pulses `start` with a sector base address, a destination byte address and a count of port-width words. The block then runs the whole device dialogue on a simple single-cycle flash bus: it clears the status register, asks for the device's write buffer, polls until the buffer is free, writes the word count, moves the data words from a valid/ready stream into consecutive flash addresses, confirms, and polls the status register until programming ends. It always finishes by clearing status, and it pulses `done` with a result code.

Commands go out replicated into every chip lane of the port, so the block serves one wide chip or several narrow chips side by side. Splitting long transfers into buffer-sized pieces and merging partial head or tail bytes belong to an outer wrapper. This block only rejects counts that it cannot issue as a single buffer load. The limit in bytes is the per-chip buffer size times the number of chips across the port.

Top module: `flash_buf_prog`

## Requirements
- R1: An accepted request writes 0x50 and then 0xE8 to the sector base. Every command byte sits in bits [7:0] of each CHIP_W-bit lane of the port word, and the upper lane bits are zero. With the default 16-bit port and 8-bit chips, 0x50 appears as 0x5050.
- R2: After 0xE8 the block reads status at the sector base. The status is sampled two cycles after each read strobe. The block repeats the read until bit 7 is set in every lane, and it writes nothing else meanwhile.
- R3: Once the buffer is free, the block writes the word count minus one, lane-replicated, to the sector base.
- R4: Data words are written in stream order. The first goes to the destination address with its low log2(DATA_W/8) bits cleared, and each later word goes DATA_W/8 bytes higher.
- R5: After the last data word the block writes 0xD0 to the sector base. It then polls status at the sector base until bit 7 is set in every lane.
- R6: The final status is ORed across lanes and decoded with this priority: bit 1 gives code 5 (locked), then bit 5 gives code 4 (sequence error), then bit 3 gives code 3 (supply voltage), then bit 4 gives code 2 (program failure). Otherwise the code is 0 (success).
- R7: Every accepted request, whether it succeeds, fails or times out, ends with a 0x50 write to the sector base. In that same cycle `done` is high for exactly one cycle and `result` holds the code.
- R8: A count of 0, or a count above BUF_BYTES*(DATA_W/CHIP_W)/(DATA_W/8) words (32 by default), gives `done` with code 6 in the cycle after `start`. No read or write strobe is issued.
- R9: While the stream has no valid word during the data phase, there is no bus write, the address does not advance and the timeout counter holds its value.
- R10: A timeout counter is cleared when 0xE8 is issued and counts the working cycles after that. If a status sample shows the device not ready and the count has reached TOUT_CYC, the block skips the remaining steps, writes 0x50 and reports code 1.
- R11: `start` is ignored while `busy` is high.
- R12: After reset, and at all other times, the read and write strobes are never high together. `in_ready` is high only in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| dest_addr | input | ADDR_W | Destination byte address of the first word |
| sect_addr | input | ADDR_W | Sector base used for commands and status |
| word_cnt | input | CNT_W | Number of port words to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with `done` |
| in_data | input | DATA_W | Stream data word |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Block accepts a stream word |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DATA_W | Flash read data, valid the cycle after `fl_re` |

## Verification
The hardest case to reach is a long data stall that lasts well beyond the timeout budget. It must not turn into a timeout, because the counter is paused while the stream is empty. The bench holds the stream empty for 300 cycles against a 120-cycle budget and expects success. Alongside that, flash-model scenarios in which the buffer or the completion never becomes ready push the counter to its limit in each polling phase. Error bits spread over different lanes exercise the decode priority.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_BRD, ST_BWAIT, ST_BCHK, ST_CNT, ST_DATA,
    ST_CONF, ST_CRD, ST_CWAIT, ST_CCHK, ST_FIN
  } fbp_state_e;

  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_BUFREQ  = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_TIMEOUT = 3'd1;
  localparam logic [2:0] RES_PROG    = 3'd2;
  localparam logic [2:0] RES_VPP     = 3'd3;
  localparam logic [2:0] RES_SEQ     = 3'd4;
  localparam logic [2:0] RES_LOCKED  = 3'd5;
  localparam logic [2:0] RES_INVALID = 3'd6;
endpackage

// File: rtl/fbp_status_decode.sv
module fbp_status_decode
  import fbp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHIP_W = 8
) (
  input  logic [DATA_W-1:0] status,
  output logic              ready,
  output logic [2:0]        code
);
  localparam int LANES = DATA_W / CHIP_W;

  logic [LANES-1:0] rdy_l, seq_l, prg_l, vpp_l, lck_l;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdy_l[g] = status[g*CHIP_W + 7];
    assign seq_l[g] = status[g*CHIP_W + 5];
    assign prg_l[g] = status[g*CHIP_W + 4];
    assign vpp_l[g] = status[g*CHIP_W + 3];
    assign lck_l[g] = status[g*CHIP_W + 1];
  end

  always_comb begin
    ready = &rdy_l;
    if (|lck_l)      code = RES_LOCKED;
    else if (|seq_l) code = RES_SEQ;
    else if (|vpp_l) code = RES_VPP;
    else if (|prg_l) code = RES_PROG;
    else             code = RES_OK;
  end
endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
  parameter int LIMIT = 1000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] value,
  output logic         expired
);
  always_ff @(posedge clk) begin
    if (rst || clr)                    value <= '0;
    else if (en && value != W'(LIMIT)) value <= value + 1'b1;
  end

  assign expired = (value == W'(LIMIT));

  AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);  // R10
endmodule

// File: rtl/flash_buf_prog.sv
module flash_buf_prog
  import fbp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int CHIP_W    = 8,
  parameter int BUF_BYTES = 32,
  parameter int CNT_W     = 8,
  parameter int TOUT_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [ADDR_W-1:0] sect_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [DATA_W-1:0] fl_rdata
);
  localparam int PORT_BYTES = DATA_W / 8;
  localparam int LANES      = DATA_W / CHIP_W;
  localparam int MAX_WORDS  = BUF_BYTES * LANES / PORT_BYTES;
  localparam int TMR_W      = $clog2(TOUT_CYC + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(PORT_BYTES - 1);

  function automatic logic [DATA_W-1:0] lane_word(input logic [7:0] b);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int l = 0; l < LANES; l++) w[l*CHIP_W +: 8] = b;
    return w;
  endfunction

  fbp_state_e        state;
  logic [ADDR_W-1:0] sect_q, baddr_q;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        cntm1_q;
  logic [2:0]        res_q;
  logic              st_ready;
  logic [2:0]        st_code;
  logic              tmr_clr, tmr_en, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              cnt_bad;

  assign cnt_bad  = (word_cnt == '0) || (word_cnt > CNT_W'(MAX_WORDS));
  assign busy     = (state != ST_IDLE);
  assign in_ready = (state == ST_DATA);
  assign tmr_clr  = (state == ST_REQ);
  assign tmr_en   = (state != ST_IDLE) && (state != ST_REQ) && (state != ST_FIN) &&
                    !((state == ST_DATA) && !in_valid);

  fbp_status_decode #(.DATA_W(DATA_W), .CHIP_W(CHIP_W)) u_dec (
    .status(fl_rdata), .ready(st_ready), .code(st_code)
  );

  fbp_timer #(.LIMIT(TOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .value(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sect_q   <= '0;
      baddr_q  <= '0;
      left_q   <= '0;
      cntm1_q  <= '0;
      res_q    <= RES_OK;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      done     <= 1'b0;
      result   <= RES_OK;
    end else begin
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (cnt_bad) begin
            done   <= 1'b1;
            result <= RES_INVALID;
          end else begin
            sect_q   <= sect_addr;
            baddr_q  <= dest_addr & ALIGN_MASK;
            left_q   <= word_cnt;
            cntm1_q  <= 8'(word_cnt - 1'b1);
            res_q    <= RES_OK;
            fl_we    <= 1'b1;
            fl_addr  <= sect_addr;
            fl_wdata <= lane_word(CMD_CLR);
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          fl_we    <= 1'b1;
          fl_addr  <= sect_q;
          fl_wdata <= lane_word(CMD_BUFREQ);
          state    <= ST_BRD;
        end
        ST_BRD, ST_CRD: begin
          fl_re   <= 1'b1;
          fl_addr <= sect_q;
          state   <= (state == ST_BRD) ? ST_BWAIT : ST_CWAIT;
        end
        ST_BWAIT: state <= ST_BCHK;
        ST_CWAIT: state <= ST_CCHK;
        ST_BCHK: begin
          if (st_ready) state <= ST_CNT;
          else if (tmr_exp) begin
            res_q <= RES_TIMEOUT;
            state <= ST_FIN;
          end else state <= ST_BRD;
        end
        ST_CNT: begin
          fl_we    <= 1'b1;
          fl_addr  <= sect_q;
          fl_wdata <= lane_word(cntm1_q);
          state    <= ST_DATA;
        end
        ST_DATA: if (in_valid) begin
          fl_we    <= 1'b1;
          fl_addr  <= baddr_q;
          fl_wdata <= in_data;
          baddr_q  <= baddr_q + ADDR_W'(PORT_BYTES);
          left_q   <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) state <= ST_CONF;
        end
        ST_CONF: begin
          fl_we    <= 1'b1;
          fl_addr  <= sect_q;
          fl_wdata <= lane_word(CMD_CONFIRM);
          state    <= ST_CRD;
        end
        ST_CCHK: begin
          if (st_ready) begin
            res_q <= st_code;
            state <= ST_FIN;
          end else if (tmr_exp) begin
            res_q <= RES_TIMEOUT;
            state <= ST_FIN;
          end else state <= ST_CRD;
        end
        ST_FIN: begin
          fl_we    <= 1'b1;
          fl_addr  <= sect_q;
          fl_wdata <= lane_word(CMD_CLR);
          done     <= 1'b1;
          result   <= res_q;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_INVALID_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (start && state == ST_IDLE && cnt_bad) |=>
      (done && result == RES_INVALID && !fl_we && !fl_re));  // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !in_valid) |=>
      (!fl_we && $stable(baddr_q) && $stable(tmr_val)));  // R9
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));  // R12
  AST_DONE_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && result != RES_INVALID) |-> (fl_we && fl_wdata == lane_word(CMD_CLR)));  // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (start && busy && state != ST_FIN) |=> (busy && $stable(sect_q)));  // R11
  AST_READY_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!fl_re && busy));  // R12
endmodule

// File: tb/test_flash_buf_prog.sv
module test_flash_buf_prog;
  localparam int ADDR_W = 24, DATA_W = 16, CHIP_W = 8, BUF_BYTES = 32;
  localparam int CNT_W = 8, TOUT = 120, MAXW = 32;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ADDR_W-1:0] dest_addr = '0, sect_addr = '0;
  logic [CNT_W-1:0]  word_cnt = '0;
  logic busy, done, in_ready, fl_we, fl_re;
  logic [2:0] result;
  logic [DATA_W-1:0] in_data = '0, fl_wdata, fl_rdata;
  logic in_valid = 1'b0;
  logic [ADDR_W-1:0] fl_addr;

  always #4 clk = ~clk;

  flash_buf_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_W(CHIP_W),
    .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .TOUT_CYC(TOUT)) i_flash_buf_prog (
    .clk(clk), .rst(rst), .start(start), .dest_addr(dest_addr),
    .sect_addr(sect_addr), .word_cnt(word_cnt), .busy(busy), .done(done),
    .result(result), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata));

  int checks = 0, errors = 0;

  // flash model configuration, written only by tasks
  logic [ADDR_W-1:0] m_sect = '0;
  int m_bpoll = 0, m_cpoll = 0, op_base = 0;
  bit m_bnever = 0, m_cnever = 0;
  logic [7:0] m_err0 = '0, m_err1 = '0;

  // flash model state, written only here
  int wr_n = 0, done_n = 0, phase = 0, pc = 0;
  logic [ADDR_W-1:0] log_a [64];
  logic [DATA_W-1:0] log_d [64];
  logic [DATA_W-1:0] rdata_q = '0;
  assign fl_rdata = rdata_q;

  always @(posedge clk) begin
    if (fl_we) begin
      if (wr_n - op_base < 64) begin
        log_a[wr_n - op_base] <= fl_addr;
        log_d[wr_n - op_base] <= fl_wdata;
      end
      wr_n <= wr_n + 1;
      if (fl_addr == m_sect && fl_wdata == 16'hE8E8) begin phase <= 1; pc <= 0; end
      if (fl_addr == m_sect && fl_wdata == 16'hD0D0) begin phase <= 2; pc <= 0; end
    end
    if (fl_re) begin
      pc <= pc + 1;
      if (phase == 1)
        rdata_q <= (!m_bnever && pc >= m_bpoll) ? 16'h8080 : 16'h0000;
      else if (phase == 2)
        rdata_q <= (!m_cnever && pc >= m_cpoll) ? {8'h80 | m_err1, 8'h80 | m_err0} : 16'h0000;
      else rdata_q <= 16'h0000;
    end
    if (done) done_n <= done_n + 1;
  end

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic int exp_code(input logic [7:0] e);
    if (e[1]) return 5;
    if (e[5]) return 4;
    if (e[3]) return 3;
    if (e[4]) return 2;
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] lw(input logic [7:0] b);
    return {b, b};
  endfunction

  logic [DATA_W-1:0] src [64];

  task automatic run_op(input logic [ADDR_W-1:0] sect, input logic [ADDR_W-1:0] dest,
                        input int cnt, input int bp, input int cp, input bit bn, input bit cn,
                        input logic [7:0] e0, input logic [7:0] e1, input int stall_pct,
                        input int long_stall, input bit poke, input string tag);
    logic [ADDR_W-1:0] ea [64];
    logic [DATA_W-1:0] ed [64];
    int en = 0, idx = 0, cyc = 0, stall_left = long_stall, dn0, got_res = -1, exp_r;
    bit rdy_prev = 0, got = 0, ok;
    logic [ADDR_W-1:0] dal;
    m_sect = sect; m_bpoll = bp; m_cpoll = cp; m_bnever = bn; m_cnever = cn;
    m_err0 = e0; m_err1 = e1;
    for (int i = 0; i < 64; i++) src[i] = 16'($urandom);
    @(negedge clk);
    op_base = wr_n; dn0 = done_n;
    sect_addr = sect; dest_addr = dest; word_cnt = CNT_W'(cnt); start = 1'b1;
    while (!got && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (in_valid && rdy_prev) idx++;
      if (done) begin got = 1; got_res = int'(result); end
      start = (poke && cyc == 6);
      if (poke && cyc == 6) begin sect_addr = sect + 24'h40; word_cnt = 8'd2; end
      if (in_ready && stall_left > 0) begin stall_left--; in_valid = 1'b0; end
      else in_valid = (idx < cnt) && (int'($urandom % 100) >= stall_pct);
      in_data = src[idx];
      rdy_prev = in_ready;
    end
    start = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // expected write sequence
    dal = dest & ~ADDR_W'(1);
    ea[en] = sect; ed[en] = lw(8'h50); en++;
    ea[en] = sect; ed[en] = lw(8'hE8); en++;
    if (!bn) begin
      ea[en] = sect; ed[en] = lw(8'(cnt - 1)); en++;
      for (int i = 0; i < cnt; i++) begin
        ea[en] = dal + ADDR_W'(2 * i); ed[en] = src[i]; en++;
      end
      ea[en] = sect; ed[en] = lw(8'hD0); en++;
    end
    ea[en] = sect; ed[en] = lw(8'h50); en++;
    exp_r = (bn || cn) ? 1 : exp_code(e0 | e1);
    check(wr_n - op_base == en, {tag, " R1 R7 write count"},
          $sformatf("actual %0d expected %0d", wr_n - op_base, en));
    ok = 1;
    for (int i = 0; i < en && i < wr_n - op_base; i++)
      if (log_a[i] != ea[i] || log_d[i] != ed[i]) begin
        if (ok) $display("FAIL %s R1 R2 R3 R4 R5 write %0d: actual %h:%h expected %h:%h",
                         tag, i, log_a[i], log_d[i], ea[i], ed[i]);
        ok = 0;
      end
    checks++; if (!ok) errors++;
    check(got_res == exp_r, {tag, " R6 R10 result"},
          $sformatf("actual %0d expected %0d", got_res, exp_r));
    check(done_n - dn0 == 1, {tag, " R7 R11 done pulses"},
          $sformatf("actual %0d expected 1", done_n - dn0));
  endtask

  task automatic run_bad(input int cnt);
    int w0, d0;
    @(negedge clk);
    w0 = wr_n; d0 = done_n;
    word_cnt = CNT_W'(cnt); sect_addr = 24'h150000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && result == 3'd6, "R8 invalid count reply",
          $sformatf("cnt %0d actual done %0b res %0d expected 1/6", cnt, done, result));
    repeat (4) @(negedge clk);
    check(wr_n == w0 && !busy && done_n - d0 == 1, "R8 no bus cycles",
          $sformatf("actual writes %0d busy %0b expected 0/0", wr_n - w0, busy));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual no completion, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !fl_we && !fl_re && !in_ready, "R12 reset state",
          $sformatf("actual busy %0b done %0b we %0b re %0b rdy %0b expected 0",
                    busy, done, fl_we, fl_re, in_ready));
    // R4: misaligned destination, one word
    run_op(24'h100000, 24'h200003, 1, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, "R4 single");
    // R2 R5: full buffer with slow buffer grant and slow completion
    run_op(24'h101000, 24'h200100, MAXW, 3, 4, 0, 0, 8'h00, 8'h00, 20, 0, 0, "R2 R5 full");
    // R8: bad counts
    run_bad(0);
    run_bad(MAXW + 1);
    // R10: buffer never granted, completion never reached
    run_op(24'h102000, 24'h200200, 4, 0, 0, 1, 0, 8'h00, 8'h00, 0, 0, 0, "R10 buffer");
    run_op(24'h103000, 24'h200300, 4, 0, 0, 0, 1, 8'h00, 8'h00, 0, 0, 0, "R10 complete");
    // R9: stall far longer than the timeout budget
    run_op(24'h104000, 24'h200400, 5, 1, 1, 0, 0, 8'h00, 8'h00, 0, 300, 0, "R9 stall");
    // R6: decode priority, errors in different lanes
    run_op(24'h105000, 24'h200500, 2, 0, 0, 0, 0, 8'h12, 8'h00, 0, 0, 0, "R6 locked");
    run_op(24'h105000, 24'h200500, 2, 0, 0, 0, 0, 8'h08, 8'h20, 0, 0, 0, "R6 seq");
    run_op(24'h105000, 24'h200500, 2, 0, 0, 0, 0, 8'h18, 8'h00, 0, 0, 0, "R6 vpp");
    run_op(24'h105000, 24'h200500, 2, 0, 2, 0, 0, 8'h00, 8'h10, 0, 0, 0, "R6 prog");
    // R11: start while busy
    run_op(24'h106000, 24'h200600, 6, 1, 1, 0, 0, 8'h00, 8'h00, 0, 0, 1, "R11 poke");
    // random mix
    for (int k = 0; k < 20; k++) begin
      logic [7:0] masks [5];
      masks[0] = 8'h00; masks[1] = 8'h02; masks[2] = 8'h20;
      masks[3] = 8'h08; masks[4] = 8'h10;
      run_op(24'h100000 + ADDR_W'(($urandom % 16) * 32'h1000),
             24'h200000 + ADDR_W'($urandom % 32'h10000),
             1 + int'($urandom % MAXW), int'($urandom % 5), int'($urandom % 6), 0, 0,
             ($urandom % 2) ? masks[$urandom % 5] : 8'h00,
             ($urandom % 2) ? masks[$urandom % 5] : 8'h00,
             int'($urandom % 60), 0, 0, "R4 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule